// File: doc/BRIEF.md
# Microwire EEPROM Host Controller

This block is the host side of a three-wire serial link to an EEPROM organised as 16-bit words. It owns chip select, the serial clock and the serial data line toward the memory, and it samples the memory's data output. A client hands it one command at a time over a valid/ready pair. There are four commands: read a run of consecutive words starting at an address, write one word, allow programming, and forbid programming.

Each frame starts with a 1 bit, then a two-bit operation code, then the address field. For a write, the data word follows. The serial clock comes from the system clock. Its half period and the minimum chip-select low time are set in nanoseconds and converted to clock counts, so the same code serves any system clock.

On a read, the controller throws away the leading zero bit from the memory and then gathers words for as long as the client asked. The address is not resent, because the memory steps and wraps its own address. After a write, the controller lowers chip select at once to start programming. It then raises chip select again and watches the data output until the memory reports ready, or until a time limit runs out.

Top module: `mw_host`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_cs` and `mem_sk` are low, `cmd_ready` is high, and `done`, `done_err` and `rd_valid` are low.
- R2: A command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from the cycle after acceptance until the cycle in which `done` pulses.
- R3: `cmd_op` selects the command: 0 read, 1 write, 2 enable programming, 3 disable programming. Each frame is sent most significant bit first, starting with a 1 and then an operation code: 10 for a read, 01 for a write, 00 for enable and disable. The address field follows. For enable, its top two bits are 11. For disable, they are 00. Any other address bits are sent as 0.
- R4: `mem_di` never changes in the cycle in which `mem_sk` rises. `mem_sk` is high only while `mem_cs` is high. Every high phase of `mem_sk`, and every low phase inside a frame, lasts at least ceil(SK_HALF_NS/CLK_NS) clocks.
- R5: Between two instructions, `mem_cs` stays low for at least ceil(CS_GAP_NS/CLK_NS) clocks.
- R6: On a read, the bit present after the last address bit is discarded. The next `DATA_W` bits, sampled on falling `mem_sk` edges, form a word, most significant bit first. One frame yields `cmd_len`+1 words, each shown on `rd_data` with a one-cycle `rd_valid` pulse, and the memory's wrap from its top address to 0 is followed.
- R7: On a write, the 16 data bits follow the address. `mem_cs` falls in the same cycle as the falling `mem_sk` edge of the last data bit, with no further rising edge. After the gap, `mem_cs` rises and `mem_do` is polled. `done` is not given until `mem_do` reads 1.
- R8: If `mem_do` stays 0 for PROG_TIMEOUT_SK×2×ceil(SK_HALF_NS/CLK_NS) clocks of polling, the controller lowers `mem_cs` and finishes with `done` and `done_err` both high.
- R9: Every command ends with exactly one `done` pulse, given while `cmd_ready` is already high. `done_err` is high only together with `done`, and is 0 on a normal finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_op | input | 2 | 0 read, 1 write, 2 enable, 3 disable |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Word to write |
| cmd_len | input | LEN_W | Read word count minus one |
| rd_valid | output | 1 | One-cycle strobe for a read word |
| rd_data | output | DATA_W | Read word |
| done | output | 1 | Command finished |
| done_err | output | 1 | Ready poll timed out (with done) |
| mem_cs | output | 1 | Memory chip select |
| mem_sk | output | 1 | Memory serial clock |
| mem_di | output | 1 | Serial data toward the memory |
| mem_do | input | 1 | Serial data from the memory |

## Verification
The hardest case to reach is the poll time limit: a working memory always turns ready, so the code that ends in an error is never entered. The bench's memory model has a switch that holds it busy after a write. The bench flips that switch for one enabled write and checks both the error flag and the elapsed cycles, then clears it and confirms a normal write still works. A second hard case is a write that the memory silently refuses. To reach it, the bench sends disable, writes, and reads the word back unchanged, which shows the disable code went out correctly.

// File: rtl/mw_host.sv
module mw_host #(
  parameter int ADDR_W          = 7,
  parameter int DATA_W          = 16,
  parameter int LEN_W           = 8,
  parameter int CLK_NS          = 10,
  parameter int SK_HALF_NS      = 500,
  parameter int CS_GAP_NS       = 250,
  parameter int PROG_TIMEOUT_SK = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              done_err,
  output logic              mem_cs,
  output logic              mem_sk,
  output logic              mem_di,
  input  logic              mem_do
);
  localparam int HALF_RAW  = (SK_HALF_NS + CLK_NS - 1) / CLK_NS;
  localparam int HALF_CLKS = HALF_RAW < 1 ? 1 : HALF_RAW;
  localparam int GAP_RAW   = (CS_GAP_NS + CLK_NS - 1) / CLK_NS;
  localparam int GAP_CLKS  = GAP_RAW < 1 ? 1 : GAP_RAW;
  localparam int TO_CLKS   = PROG_TIMEOUT_SK * 2 * HALF_CLKS;
  localparam int TMAX      = TO_CLKS > GAP_CLKS ? TO_CLKS : GAP_CLKS;
  localparam int TW        = $clog2(TMAX + 1);
  localparam int HW        = $clog2(HALF_CLKS + 1);
  localparam int FRAME_W   = 3 + ADDR_W + DATA_W;
  localparam int BW        = $clog2(FRAME_W + 1);
  localparam int RW        = $clog2(DATA_W);

  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_EN = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_RECV, S_GAP, S_POLL} st_t;

  st_t               st;
  logic [1:0]        op;
  logic [FRAME_W-1:0] frame;
  logic [BW-1:0]     bits;
  logic [HW-1:0]     hcnt;
  logic [RW-1:0]     rcnt;
  logic [LEN_W-1:0]  wleft;
  logic [TW-1:0]     tcnt;
  logic [DATA_W-2:0] rdsh;
  logic              pend_poll, err;

  wire tick    = (hcnt == HW'(HALF_CLKS - 1));
  wire fall    = tick && mem_sk;
  assign cmd_ready = (st == S_IDLE);
  assign mem_di    = (st == S_SEND) && frame[FRAME_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_RD; frame <= '0; bits <= '0; hcnt <= '0;
      rcnt <= '0; wleft <= '0; tcnt <= '0; rdsh <= '0; pend_poll <= 1'b0;
      err <= 1'b0; mem_cs <= 1'b0; mem_sk <= 1'b0;
      rd_valid <= 1'b0; rd_data <= '0; done <= 1'b0; done_err <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      done_err <= 1'b0;
      if (st == S_SEND || st == S_RECV) begin
        hcnt <= tick ? '0 : hcnt + 1'b1;
        if (tick) mem_sk <= ~mem_sk;
      end
      case (st)
        S_IDLE: if (cmd_valid) begin
          op <= cmd_op; wleft <= cmd_len; err <= 1'b0;
          mem_cs <= 1'b1; mem_sk <= 1'b0; hcnt <= '0;
          bits <= (cmd_op == OP_WR) ? BW'(FRAME_W) : BW'(3 + ADDR_W);
          case (cmd_op)
            OP_RD:   frame <= {3'b110, cmd_addr, {DATA_W{1'b0}}};
            OP_WR:   frame <= {3'b101, cmd_addr, cmd_wdata};
            OP_EN:   frame <= {3'b100, 2'b11, {(ADDR_W-2){1'b0}}, {DATA_W{1'b0}}};
            default: frame <= {3'b100, {ADDR_W{1'b0}}, {DATA_W{1'b0}}};
          endcase
          st <= S_SEND;
        end
        S_SEND: if (fall) begin
          frame <= {frame[FRAME_W-2:0], 1'b0};
          bits  <= bits - 1'b1;
          if (bits == BW'(1)) begin
            if (op == OP_RD) begin
              rcnt <= '0;
              st   <= S_RECV;
            end else begin
              mem_cs <= 1'b0; tcnt <= '0;
              pend_poll <= (op == OP_WR);
              st <= S_GAP;
            end
          end
        end
        S_RECV: if (fall) begin
          rdsh <= {rdsh[DATA_W-3:0], mem_do};
          rcnt <= rcnt + 1'b1;
          if (rcnt == RW'(DATA_W - 1)) begin
            rd_valid <= 1'b1;
            rd_data  <= {rdsh, mem_do};
            rcnt     <= '0;
            if (wleft == '0) begin
              mem_cs <= 1'b0; tcnt <= '0; pend_poll <= 1'b0;
              st <= S_GAP;
            end else begin
              wleft <= wleft - 1'b1;
            end
          end
        end
        S_GAP: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == TW'(GAP_CLKS - 1)) begin
            tcnt <= '0;
            if (pend_poll) begin
              mem_cs <= 1'b1;
              st     <= S_POLL;
            end else begin
              done     <= 1'b1;
              done_err <= err;
              st       <= S_IDLE;
            end
          end
        end
        S_POLL: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt != '0 && mem_do) begin
            mem_cs <= 1'b0; pend_poll <= 1'b0; tcnt <= '0;
            st <= S_GAP;
          end else if (tcnt == TW'(TO_CLKS - 1)) begin
            mem_cs <= 1'b0; pend_poll <= 1'b0; tcnt <= '0; err <= 1'b1;
            st <= S_GAP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_host_chk.sv
module mw_host_chk #(
  parameter int GAP = 1
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic done,
  input logic done_err,
  input logic mem_cs,
  input logic mem_sk,
  input logic mem_di
);
  int low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_run <= GAP;
    else if (mem_cs)       low_run <= 0;
    else if (low_run < GAP) low_run <= low_run + 1;
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  p_di_held_at_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_sk) |-> $stable(mem_di));

  p_sk_inside_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sk |-> mem_cs);

  p_cs_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs) |-> low_run >= GAP);

  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);

  p_done_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
endmodule

bind mw_host mw_host_chk #(.GAP(GAP_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .done(done), .done_err(done_err), .mem_cs(mem_cs), .mem_sk(mem_sk),
  .mem_di(mem_di)
);

// File: tb/mw_host_tb.sv
module mw_host_tb_top;
  localparam int AW   = 4;
  localparam int LW   = 5;
  localparam int HALF = 2;
  localparam int GAPC = 5;
  localparam int TO   = 30 * 2 * HALF;
  localparam int PROG = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic [LW-1:0] cmd_len = '0;
  logic cmd_ready, rd_valid, done, done_err, mem_cs, mem_sk, mem_di, mem_do;
  logic [15:0] rd_data;

  always #5 clk = ~clk;

  mw_host #(.ADDR_W(AW), .DATA_W(16), .LEN_W(LW), .CLK_NS(10), .SK_HALF_NS(20),
            .CS_GAP_NS(50), .PROG_TIMEOUT_SK(30)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .done_err(done_err),
    .mem_cs(mem_cs), .mem_sk(mem_sk), .mem_di(mem_di), .mem_do(mem_do));

  // memory model
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] mem [16] = '{default: 16'h0};
  logic m_started = 1'b0, m_reading = 1'b0, m_dout = 1'b0, m_en = 1'b0, m_pv = 1'b0;
  logic [1:0] m_op = 2'b0;
  logic [AW-1:0] m_addr = '0;
  logic [15:0] m_data = '0;
  int m_cnt = 0, m_rbit = 0, m_prog_at = 0;
  logic stuck = 1'b0;
  logic dev_busy;

  assign dev_busy = m_pv && (stuck || (cyc - m_prog_at) < PROG);
  assign mem_do = !mem_cs ? 1'b0 : (!m_started ? !dev_busy : m_dout);

  always @(posedge mem_sk or negedge mem_cs) begin
    if (!mem_cs) begin
      if (m_started && m_op == 2'b01 && m_cnt == 2 + AW + 16 && m_en) begin
        mem[m_addr] <= m_data;
        m_pv <= 1'b1;
        m_prog_at <= cyc;
      end
      m_started <= 1'b0; m_cnt <= 0; m_reading <= 1'b0; m_dout <= 1'b0;
    end else if (!m_started) begin
      if (mem_di) m_started <= 1'b1;
    end else if (m_reading) begin
      m_dout <= mem[m_addr][15 - m_rbit];
      if (m_rbit == 15) begin
        m_rbit <= 0;
        m_addr <= m_addr + 1'b1;
      end else m_rbit <= m_rbit + 1;
    end else begin
      m_cnt <= m_cnt + 1;
      if (m_cnt < 2) m_op <= {m_op[0], mem_di};
      else if (m_cnt < 2 + AW) m_addr <= {m_addr[AW-2:0], mem_di};
      else m_data <= {m_data[14:0], mem_di};
      if (m_cnt == 2 + AW - 1) begin
        if (m_op == 2'b10) begin
          m_reading <= 1'b1; m_dout <= 1'b0; m_rbit <= 0;
        end else if (m_op == 2'b00) begin
          if ({m_addr[AW-2], m_addr[AW-3]} == 2'b11) m_en <= 1'b1;
          else if ({m_addr[AW-2], m_addr[AW-3]} == 2'b00) m_en <= 1'b0;
        end
      end
    end
  end

  // pin timing monitors
  int hi_run = 0, lo_run = 0, cs_lo_run = 1000;
  int min_hi = 1000, min_lo = 1000, min_cs_lo = 1000;
  always @(posedge clk) begin
    if (mem_sk) hi_run = hi_run + 1;
    else if (hi_run > 0) begin
      if (hi_run < min_hi) min_hi = hi_run;
      hi_run = 0;
    end
    if (mem_cs && !mem_sk) lo_run = lo_run + 1;
    else begin
      if (mem_sk && lo_run > 0 && lo_run < min_lo) min_lo = lo_run;
      lo_run = 0;
    end
    if (!mem_cs) cs_lo_run = cs_lo_run + 1;
    else begin
      if (cs_lo_run > 0 && cs_lo_run < min_cs_lo) min_cs_lo = cs_lo_run;
      cs_lo_run = 0;
    end
  end

  int n_chk = 0, n_bad = 0;
  logic finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  logic [15:0] rbuf [32];

  task automatic run_cmd(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [15:0] d, input int len,
                         output int nrd, output logic err, output int cycles);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_len = LW'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
    cycles = 1;
    chk(cmd_ready == 1'b0, "R2", "ready after accept", cmd_ready, 0);
    nrd = 0;
    err = 1'b0;
    while (1) begin
      if (rd_valid) begin
        if (nrd < 32) rbuf[nrd] = rd_data;
        nrd++;
      end
      if (done) begin
        err = done_err;
        break;
      end
      @(negedge clk);
      cycles++;
    end
  endtask

  // op[26:25] addr[24:21] data[20:5] len[4:0]
  localparam int NV = 15;
  localparam logic [26:0] VEC [NV] = '{
    {2'd1, 4'd3,  16'hAAAA, 5'd0},
    {2'd0, 4'd3,  16'h0000, 5'd0},
    {2'd2, 4'd0,  16'h0000, 5'd0},
    {2'd1, 4'd3,  16'h1234, 5'd0},
    {2'd1, 4'd15, 16'hBEEF, 5'd0},
    {2'd1, 4'd0,  16'h0F0F, 5'd0},
    {2'd1, 4'd7,  16'h8001, 5'd0},
    {2'd0, 4'd3,  16'h0000, 5'd0},
    {2'd0, 4'd15, 16'h0000, 5'd1},
    {2'd0, 4'd6,  16'h0000, 5'd2},
    {2'd3, 4'd0,  16'h0000, 5'd0},
    {2'd1, 4'd7,  16'hFFFF, 5'd0},
    {2'd0, 4'd7,  16'h0000, 5'd0},
    {2'd2, 4'd0,  16'h0000, 5'd0},
    {2'd1, 4'd7,  16'h5A5A, 5'd0}
  };

  logic [15:0] shadow [16] = '{default: 16'h0};
  logic sh_en = 1'b0;

  initial begin
    int nrd, cyc_n;
    logic err;
    repeat (3) @(negedge clk);
    chk(mem_cs == 0 && mem_sk == 0, "R1", "pins in reset", {mem_cs, mem_sk}, 0);
    chk(cmd_ready == 1, "R1", "ready in reset", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && done_err == 0 && rd_valid == 0, "R1", "strobes after reset",
        {done, done_err, rd_valid}, 0);
    chk(mem_cs == 0 && cmd_ready == 1, "R1", "idle after reset", {mem_cs, cmd_ready}, 1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [AW-1:0] a;
      logic [15:0] d;
      int len;
      op = VEC[i][26:25]; a = VEC[i][24:21]; d = VEC[i][20:5]; len = int'(VEC[i][4:0]);
      run_cmd(op, a, d, len, nrd, err, cyc_n);
      chk(err == 1'b0, "R9", "done_err on normal finish", err, 0);
      case (op)
        2'd0: begin
          chk(nrd == len + 1, "R6", "word count", nrd, len + 1);
          for (int k = 0; k < len + 1 && k < 32; k++)
            chk(rbuf[k] === shadow[AW'(int'(a) + k)], "R6", "read word (R3 enable/disable effect)",
                rbuf[k], shadow[AW'(int'(a) + k)]);
        end
        2'd1: begin
          chk(dev_busy == 1'b0, "R7", "done before device ready", dev_busy, 0);
          if (sh_en) shadow[a] = d;
        end
        2'd2: sh_en = 1'b1;
        default: sh_en = 1'b0;
      endcase
    end
    run_cmd(2'd0, 4'd7, 16'h0, 0, nrd, err, cyc_n);
    chk(rbuf[0] == 16'h5A5A, "R7", "re-enabled write stored", rbuf[0], 16'h5A5A);

    stuck = 1'b1;
    run_cmd(2'd1, 4'd9, 16'hC3C3, 0, nrd, err, cyc_n);
    chk(err == 1'b1, "R8", "timeout flagged", err, 1);
    chk(cyc_n >= 92 + GAPC + TO && cyc_n <= 92 + 2 * GAPC + TO + 8, "R8",
        "timeout duration", cyc_n, 92 + 2 * GAPC + TO);
    chk(mem_cs == 1'b0, "R8", "cs low after timeout", mem_cs, 0);
    stuck = 1'b0;
    run_cmd(2'd1, 4'd9, 16'h3C3C, 0, nrd, err, cyc_n);
    chk(err == 1'b0, "R9", "recovery write clean", err, 0);
    run_cmd(2'd0, 4'd9, 16'h0, 0, nrd, err, cyc_n);
    chk(rbuf[0] == 16'h3C3C, "R7", "recovery write stored", rbuf[0], 16'h3C3C);

    chk(min_hi >= HALF, "R4", "min sk high", min_hi, HALF);
    chk(min_lo >= HALF, "R4", "min sk low", min_lo, HALF);
    chk(min_cs_lo >= GAPC, "R5", "min cs low", min_cs_lo, GAPC);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule